// File: doc/BRIEF.md
# Memory Bus Gateway

This block sits between a processor's 32-bit internal bus and an external system bus. The external side has a 32-bit address, a 64-bit bidirectional data bus, separate read and write strobes and a ready input from the addressed memory or device. Inside, it keeps an address register and a 64-bit data register. The address register is loaded in one step from the internal bus. The data register is loaded one 32-bit half at a time, and it is read back onto the internal bus the same way, with a half-select input choosing the half.

The control unit first loads the address and, for a write, the data. It then issues a command on a valid/ready pair. The block accepts a command only when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is low for the whole transfer, so a requester that holds `cmd_valid` simply waits. A valid seen while ready is low is dropped, not queued. After acceptance the block raises the matching strobe, drives the data bus on a write, and holds everything steady until a slow target answers with ready. On a read it captures the data bus at that edge. It then drops the strobe and pulses `done` for one cycle.

Top module: `bus_gate`

## Requirements
- R1: After synchronous active-high reset, both strobes, `data_oe`, `busy` and `done` are low, `cmd_ready` is high, and the address bus and both data-register halves read zero.
- R2: With `mar_load` high while idle, the address register takes `ibus_in` at the clock edge. `ext_addr` shows the address register at all times.
- R3: With `mdr_load` high while idle, `mdr_sel`=0 writes `ibus_in` into data-register bits 31:0 and `mdr_sel`=1 writes it into bits 63:32, leaving the other half unchanged. `ibus_out` shows the half picked by `mdr_sel` without delay.
- R4: A command is taken when `cmd_valid` and `cmd_ready` are both high at an edge. From the next cycle `busy` is high, `cmd_ready` is low, and `ext_wr` is high if `cmd_write`=1 or `ext_rd` is high if `cmd_write`=0.
- R5: During a write, `data_oe` is high and `ext_data` carries the data register. Address, data and strobe stay unchanged until `ext_rdy` is sampled high.
- R6: During a read, `data_oe` stays low. The data register takes `ext_data` at the edge where `ext_rdy` is sampled high, and not before.
- R7: In the cycle after `ext_rdy` is sampled high during a transfer, both strobes and `data_oe` are low, `busy` is low and `done` is high for exactly that one cycle.
- R8: `ext_rd` and `ext_wr` are never high in the same cycle.
- R9: While busy, `cmd_valid`, `mar_load` and `mdr_load` have no effect on the address register, the data register or the transfer in progress.
- R10: `ext_rdy` while idle produces no `done` and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ibus_in | input | 32 | Internal bus value for register loads |
| ibus_out | output | 32 | Selected data-register half toward the internal bus |
| mar_load | input | 1 | Load address register from `ibus_in` |
| mdr_load | input | 1 | Load selected data-register half from `ibus_in` |
| mdr_sel | input | 1 | Half select: 0 = bits 31:0, 1 = bits 63:32 |
| cmd_valid | input | 1 | Transfer request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ready | output | 1 | Block can accept a request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ext_addr | output | 32 | External address bus |
| ext_data | inout | 64 | External bidirectional data bus |
| data_oe | output | 1 | Block is driving `ext_data` |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_rdy | input | 1 | Ready/acknowledge from the target |

## Verification
The checker watches several rules on every cycle. The two strobes never overlap, and the data bus is driven only under the write strobe. The strobes fall in the cycle after ready is sampled, and the address stays stable while a strobe waits for ready. `done` lasts a single cycle and only follows a ready sampled during a transfer. Other behaviour needs the bench's scenarios. These include the half-wise loading and read-back of the data register, the value captured on a read, the data presented on a write, and the proof that loads and commands issued mid-transfer leave the registers untouched. For these the bench drives random addresses, data and wait lengths and compares what it sees at the ports with values it computes itself.

// File: rtl/bus_gate_pkg.sv
package bus_gate_pkg;
  typedef enum logic [1:0] {
    BG_IDLE  = 2'd0,
    BG_READ  = 2'd1,
    BG_WRITE = 2'd2
  } bg_state_e;
endpackage

// File: rtl/bus_gate_mar.sv
module bus_gate_mar #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= din;
  end
endmodule

// File: rtl/bus_gate_mdr.sv
module bus_gate_mdr #(
  parameter int IW   = 32,
  parameter int DW   = 64,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lane_we,
  input  logic [SELW-1:0] lane_sel,
  input  logic [IW-1:0]   ibus_in,
  input  logic            cap_en,
  input  logic [DW-1:0]   ext_in,
  output logic [DW-1:0]   q,
  output logic [IW-1:0]   lane_out
);
  localparam int LANES = DW / IW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        q[g*IW +: IW] <= '0;
      else if (cap_en)
        q[g*IW +: IW] <= ext_in[g*IW +: IW];
      else if (lane_we && (int'(lane_sel) == g))
        q[g*IW +: IW] <= ibus_in;
    end
  end

  assign lane_out = q[int'(lane_sel)*IW +: IW];
endmodule

// File: rtl/bus_gate_seq.sv
module bus_gate_seq
  import bus_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_fire,
  input  logic cmd_write,
  input  logic ext_rdy,
  output logic busy,
  output logic rd_stb,
  output logic wr_stb,
  output logic drive_en,
  output logic done,
  output logic cap_en
);
  bg_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BG_IDLE;
      done    <= 1'b0;
    end else begin
      done <= (state_q != BG_IDLE) && ext_rdy;
      case (state_q)
        BG_IDLE:  if (cmd_fire) state_q <= cmd_write ? BG_WRITE : BG_READ;
        BG_READ,
        BG_WRITE: if (ext_rdy)  state_q <= BG_IDLE;
        default:  state_q <= BG_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != BG_IDLE);
  assign rd_stb   = (state_q == BG_READ);
  assign wr_stb   = (state_q == BG_WRITE);
  assign drive_en = (state_q == BG_WRITE);
  assign cap_en   = (state_q == BG_READ) && ext_rdy;
endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ibus_in,
  output logic [IW-1:0] ibus_out,
  input  logic          mar_load,
  input  logic          mdr_load,
  input  logic          mdr_sel,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  output logic          cmd_ready,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ext_addr,
  inout  wire  [DW-1:0] ext_data,
  output logic          data_oe,
  output logic          ext_rd,
  output logic          ext_wr,
  input  logic          ext_rdy
);
  localparam int SELW = 1;

  logic          cap_en;
  logic [DW-1:0] mdr_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] ext_in;

  assign cmd_ready = !busy;

  bus_gate_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_fire (cmd_valid && cmd_ready),
    .cmd_write(cmd_write),
    .ext_rdy  (ext_rdy),
    .busy     (busy),
    .rd_stb   (ext_rd),
    .wr_stb   (ext_wr),
    .drive_en (data_oe),
    .done     (done),
    .cap_en   (cap_en)
  );

  bus_gate_mar #(.AW(AW)) u_mar (
    .clk    (clk),
    .rst    (rst),
    .load_en(mar_load && !busy),
    .din    (ibus_in[AW-1:0]),
    .q      (mar_q)
  );

  bus_gate_mdr #(.IW(IW), .DW(DW), .SELW(SELW)) u_mdr (
    .clk     (clk),
    .rst     (rst),
    .lane_we (mdr_load && !busy),
    .lane_sel(mdr_sel),
    .ibus_in (ibus_in),
    .cap_en  (cap_en),
    .ext_in  (ext_in),
    .q       (mdr_q),
    .lane_out(ibus_out)
  );

  assign ext_addr = mar_q;
  assign ext_in   = ext_data;
  assign ext_data = data_oe ? mdr_q : {DW{1'bz}};
endmodule

// File: rtl/bus_gate_chk.sv
module bus_gate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_rd,
  input logic          ext_wr,
  input logic          ext_rdy,
  input logic          data_oe,
  input logic          done,
  input logic          busy,
  input logic [AW-1:0] ext_addr
);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));

  // R5
  drive_under_wr_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ext_wr);

  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rd |-> !data_oe);

  // R7
  strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((ext_rd || ext_wr) && ext_rdy) |=> (!ext_rd && !ext_wr && !busy && done));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ext_rd || ext_wr) && !ext_rdy) |=> ($stable(ext_addr) && (ext_rd || ext_wr)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past((ext_rd || ext_wr) && ext_rdy));
endmodule

bind bus_gate bus_gate_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_rd  (ext_rd),
  .ext_wr  (ext_wr),
  .ext_rdy (ext_rdy),
  .data_oe (data_oe),
  .done    (done),
  .busy    (busy),
  .ext_addr(ext_addr)
);

// File: tb/bus_gate_test.sv
`timescale 1ns/1ps
module bus_gate_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ibus_in;
  logic [31:0] ibus_out;
  logic        mar_load, mdr_load, mdr_sel;
  logic        cmd_valid, cmd_write, cmd_ready;
  logic        busy, done, data_oe, ext_rd, ext_wr, ext_rdy;
  logic [31:0] ext_addr;
  wire  [63:0] ext_data;
  logic        tb_drv;
  logic [63:0] tb_val;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  assign ext_data = tb_drv ? tb_val : {64{1'bz}};

  always #10 clk = ~clk;

  bus_gate uut (
    .clk(clk), .rst(rst), .ibus_in(ibus_in), .ibus_out(ibus_out),
    .mar_load(mar_load), .mdr_load(mdr_load), .mdr_sel(mdr_sel),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .ext_addr(ext_addr), .ext_data(ext_data),
    .data_oe(data_oe), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_rdy(ext_rdy)
  );

  function automatic logic [31:0] half_of(logic [63:0] v, logic sel);
    return sel ? v[63:32] : v[31:0];
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_mdr(logic [63:0] exp, string tag);
    mdr_sel = 1'b0; #1;
    check(ibus_out == half_of(exp, 1'b0), tag, {32'd0, ibus_out}, {32'd0, half_of(exp, 1'b0)});
    mdr_sel = 1'b1; #1;
    check(ibus_out == half_of(exp, 1'b1), tag, {32'd0, ibus_out}, {32'd0, half_of(exp, 1'b1)});
  endtask

  // R2 R3: load address and both data halves while idle
  task automatic load_regs(logic [31:0] a, logic [63:0] d);
    ibus_in = a; mar_load = 1'b1; tick();
    mar_load = 1'b0; mdr_load = 1'b1; mdr_sel = 1'b0; ibus_in = d[31:0]; tick();
    mdr_sel = 1'b1; ibus_in = d[63:32]; tick();
    mdr_load = 1'b0;
    check(ext_addr == a, "R2 address bus shows loaded address", {32'd0, ext_addr}, {32'd0, a});
  endtask

  task automatic transfer(bit wr, logic [31:0] a, logic [63:0] d, logic [63:0] rdat, int waits);
    logic [63:0] exp_mdr;
    check(cmd_ready == 1'b1, "R4 ready while idle", {63'd0, cmd_ready}, 64'd1);
    cmd_valid = 1'b1; cmd_write = wr; tick();
    cmd_valid = 1'b0;
    // R9: disturbances during the first busy cycle
    cmd_valid = 1'b1; cmd_write = !wr;
    mar_load = 1'b1; mdr_load = 1'b1; mdr_sel = $urandom_range(0, 1);
    ibus_in = ~a;
    check(busy && !cmd_ready, "R4 busy after accept", {62'd0, busy, cmd_ready}, 64'd2);
    check(ext_wr == wr && ext_rd == !wr, "R4 strobe matches command",
          {62'd0, ext_wr, ext_rd}, {62'd0, wr, !wr});
    for (int i = 0; i < waits; i++) begin
      check(ext_addr == a, "R5 address held while waiting", {32'd0, ext_addr}, {32'd0, a});
      check(data_oe == wr, "R5 R6 drive enable matches direction", {63'd0, data_oe}, {63'd0, wr});
      if (wr) check(ext_data == d, "R5 write data on bus", ext_data, d);
      if (!wr) begin
        tb_drv = 1'b1; tb_val = ~rdat;
      end
      tick();
      cmd_valid = 1'b0; mar_load = 1'b0; mdr_load = 1'b0;
      check(busy, "R5 still busy without ready", {63'd0, busy}, 64'd1);
    end
    if (wr) check(ext_data == d, "R5 write data before ready", ext_data, d);
    if (!wr) begin
      tb_drv = 1'b1; tb_val = rdat;
    end
    ext_rdy = 1'b1; tick();
    cmd_valid = 1'b0; mar_load = 1'b0; mdr_load = 1'b0;
    ext_rdy = 1'b0; tb_drv = 1'b0;
    check(!ext_rd && !ext_wr && !data_oe, "R7 strobes low after ready",
          {61'd0, ext_rd, ext_wr, data_oe}, 64'd0);
    check(done && !busy, "R7 done pulse and not busy", {62'd0, done, busy}, 64'd2);
    tick();
    check(!done, "R7 done lasts one cycle", {63'd0, done}, 64'd0);
    check(ext_addr == a, "R9 address not changed during transfer", {32'd0, ext_addr}, {32'd0, a});
    exp_mdr = wr ? d : rdat;
    check_mdr(exp_mdr, wr ? "R9 data register kept through write" : "R6 read data captured");
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; ibus_in = '0; mar_load = 0; mdr_load = 0; mdr_sel = 0;
    cmd_valid = 0; cmd_write = 0; ext_rdy = 0; tb_drv = 0; tb_val = '0;
    tick(); tick();
    rst = 1'b0; tick();
    // R1
    check(!ext_rd && !ext_wr && !data_oe && !busy && !done && cmd_ready,
          "R1 reset state", {58'd0, ext_rd, ext_wr, data_oe, busy, done, cmd_ready}, 64'd1);
    check(ext_addr == 32'd0, "R1 address zero", {32'd0, ext_addr}, 64'd0);
    check_mdr(64'd0, "R1 data register zero");

    // R3: one half load leaves other untouched
    mdr_load = 1'b1; mdr_sel = 1'b1; ibus_in = 32'hA5A5_0F0F; tick();
    mdr_load = 1'b0;
    check_mdr({32'hA5A5_0F0F, 32'd0}, "R3 upper half only");

    // R10: ready while idle
    ext_rdy = 1'b1; tick(); ext_rdy = 1'b0;
    check(!done && !ext_rd && !ext_wr, "R10 idle ready ignored",
          {61'd0, done, ext_rd, ext_wr}, 64'd0);
    tick();
    check(!done, "R10 no late done", {63'd0, done}, 64'd0);

    // directed corners: zero wait write, zero wait read, all-ones patterns
    load_regs(32'hFFFF_FFFF, 64'hFFFF_FFFF_0000_0000);
    transfer(1'b1, 32'hFFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'd0, 0);
    load_regs(32'h0000_0004, 64'h0);
    transfer(1'b0, 32'h0000_0004, 64'h0, 64'h0123_4567_89AB_CDEF, 0);

    // random transfers
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a;
      logic [63:0] d, r;
      bit w;
      a = $urandom(); d = {$urandom(), $urandom()}; r = {$urandom(), $urandom()};
      w = $urandom_range(0, 1);
      load_regs(a, d);
      transfer(w, a, d, r, $urandom_range(0, 6));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule